// File: doc/BRIEF.md
# Energy Efficient Ethernet Low-Power Idle Controller

This block decides, on the transmit side of an Ethernet MAC, when the low-power idle (LPI) request may be raised towards the transmit datapath and when normal transmission may resume afterwards. Software sets it up through a small register interface. The interface holds the enable bits, a link-good bit that software keeps in step with the PHY, an enable for transmit clock gating, and one register with two timers. The MAC supplies a millisecond tick, a microsecond tick, a transmit-idle indication and a frame-pending indication.

LPI may start only when all of the following hold: the link-good bit has been set for at least the programmed number of millisecond ticks, the transmitter is idle and no frame is waiting. The request is dropped as soon as a frame is pending, the link is reported down, or both enables are cleared. Transmission stays blocked until the programmed number of microsecond ticks has elapsed after the request falls. Two sticky flags record LPI entry and LPI exit. Reading the control register clears both flags.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, `lpi_req` and `tx_clk_gate` are 0, `tx_ready` is 1, and both registers read as zero.
- R2: Register address 0 is control and status. Bit 0 is the LPI enable, bit 1 is the automatic re-entry enable, bit 2 is link-good and bit 3 is the clock-gate enable, all read/write. Bit 8 is the entry flag and bit 9 is the exit flag, both read-only. Address 1 holds the link-stable time in bits 25:16 (10 bits, in ms ticks) and the wake time in bits 15:0 (16 bits, in us ticks). All other bits read as 0.
- R3: `lpi_req` rises only after link-good has been held through at least the link-stable number of `ms_tick` pulses while either enable is set.
- R4: While link-good is 0, the link-stable count is held at zero and LPI cannot start. Clearing link-good while in LPI drops `lpi_req` on the next cycle.
- R5: In LPI, `tx_pending` high or both enables cleared drops `lpi_req` on the next clock edge and starts the wake wait.
- R6: `tx_ready` is 0 while LPI is active and during the wake wait. The wake wait ends after the wake-time number of `us_tick` pulses plus one cycle. `tx_ready` is 1 in all other states.
- R7: After a wake, if the automatic bit is set the block re-arms on its own. If only the LPI enable is set, it stays in transmit mode until a control write with bit 0 set re-arms it.
- R8: `tx_clk_gate` equals `lpi_req` ANDed with the clock-gate enable.
- R9: The entry flag sets when LPI starts and the exit flag sets when LPI ends. A read of address 0 clears both, except that a flag set in the same cycle as the read is kept.
- R10: LPI does not start while `tx_idle` is 0 or `tx_pending` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags at address 0) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ms_tick | input | 1 | One-cycle millisecond time-base pulse |
| us_tick | input | 1 | One-cycle microsecond time-base pulse |
| tx_idle | input | 1 | Transmit path idle |
| tx_pending | input | 1 | A frame is waiting to be sent |
| lpi_req | output | 1 | LPI request to the transmit datapath |
| tx_ready | output | 1 | Transmission allowed |
| tx_clk_gate | output | 1 | Transmit clock may be gated |

## Verification
The hardest case to reach is a link-stable count that must restart from zero after link-good has dropped in the middle of LPI. Reaching it needs a full entry, a link-down exit, a full wake wait and a manual re-arm, with the millisecond ticks counted exactly on both sides of the threshold. The stimulus walks through that sequence with explicit tick counts. Every clock, a behavioural model predicts `lpi_req`, `tx_ready` and `tx_clk_gate`, so off-by-one errors in either timer show up as soon as they occur.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  typedef enum logic [2:0] {
    LPI_OFF  = 3'd0,
    LPI_ARM  = 3'd1,
    LPI_ON   = 3'd2,
    LPI_WAKE = 3'd3,
    LPI_RUN  = 3'd4
  } lpi_state_e;

  // control/status register bit positions (software-visible layout)
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_AUTO_BIT = 1;
  localparam int CTL_LINK_BIT = 2;
  localparam int CTL_GATE_BIT = 3;
  localparam int STA_ENT_BIT  = 8;
  localparam int STA_EXIT_BIT = 9;

  // timer register field base positions
  localparam int TW_LSB = 0;
  localparam int LS_LSB = 16;

endpackage

// File: rtl/lpi_rst_sync.sv
module lpi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpi_regs.sv
module lpi_regs
  import eee_lpi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int LS_W   = 10,
  parameter int TW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              set_entered,
  input  logic              set_exited,
  output logic              ctl_en,
  output logic              ctl_auto,
  output logic              ctl_link,
  output logic              ctl_gate,
  output logic [LS_W-1:0]   ls_time,
  output logic [TW_W-1:0]   tw_time,
  output logic              rearm,
  output logic              sta_entered,
  output logic              sta_exited
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(1);
  localparam int LS_MSB = LS_LSB + LS_W - 1;
  localparam int TW_MSB = TW_LSB + TW_W - 1;

  logic ctl_we, tmr_we, sta_clr;
  logic ent_nxt, exit_nxt;
  logic unused_wdata;

  assign ctl_we  = reg_wr && (reg_addr == A_CTL);
  assign tmr_we  = reg_wr && (reg_addr == A_TMR);
  assign sta_clr = reg_rd && (reg_addr == A_CTL);
  assign rearm   = ctl_we && reg_wdata[CTL_EN_BIT];
  assign unused_wdata = ^reg_wdata;

  // a set in the same cycle as the clearing read wins
  assign ent_nxt  = set_entered | (sta_entered & ~sta_clr);
  assign exit_nxt = set_exited  | (sta_exited  & ~sta_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_auto <= 1'b0;
      ctl_link <= 1'b0;
      ctl_gate <= 1'b0;
    end else if (ctl_we) begin
      ctl_en   <= reg_wdata[CTL_EN_BIT];
      ctl_auto <= reg_wdata[CTL_AUTO_BIT];
      ctl_link <= reg_wdata[CTL_LINK_BIT];
      ctl_gate <= reg_wdata[CTL_GATE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_time <= '0;
      tw_time <= '0;
    end else if (tmr_we) begin
      ls_time <= reg_wdata[LS_MSB:LS_LSB];
      tw_time <= reg_wdata[TW_MSB:TW_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_entered <= 1'b0;
      sta_exited  <= 1'b0;
    end else begin
      sta_entered <= ent_nxt;
      sta_exited  <= exit_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL: begin
        reg_rdata[CTL_EN_BIT]   = ctl_en;
        reg_rdata[CTL_AUTO_BIT] = ctl_auto;
        reg_rdata[CTL_LINK_BIT] = ctl_link;
        reg_rdata[CTL_GATE_BIT] = ctl_gate;
        reg_rdata[STA_ENT_BIT]  = sta_entered;
        reg_rdata[STA_EXIT_BIT] = sta_exited;
      end
      A_TMR: begin
        reg_rdata[LS_MSB:LS_LSB] = ls_time;
        reg_rdata[TW_MSB:TW_LSB] = tw_time;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lpi_link_timer.sv
module lpi_link_timer #(
  parameter int LS_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_ok,
  input  logic            ms_tick,
  input  logic [LS_W-1:0] ls_time,
  output logic            link_stable
);
  logic [LS_W-1:0] ms_cnt, ms_cnt_nxt;
  logic            cnt_en;

  assign cnt_en = link_ok && ms_tick && (ms_cnt < ls_time);

  always_comb begin
    ms_cnt_nxt = ms_cnt;
    if (!link_ok)    ms_cnt_nxt = '0;
    else if (cnt_en) ms_cnt_nxt = ms_cnt + LS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ms_cnt <= '0;
    else        ms_cnt <= ms_cnt_nxt;
  end

  assign link_stable = link_ok && (ms_cnt >= ls_time);
endmodule

// File: rtl/lpi_wake_timer.sv
module lpi_wake_timer #(
  parameter int TW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TW_W-1:0] load_val,
  input  logic            us_tick,
  output logic            done
);
  logic [TW_W-1:0] us_cnt, us_cnt_nxt;

  always_comb begin
    us_cnt_nxt = us_cnt;
    if (load)                          us_cnt_nxt = load_val;
    else if (us_tick && us_cnt != '0)  us_cnt_nxt = us_cnt - TW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) us_cnt <= '0;
    else        us_cnt <= us_cnt_nxt;
  end

  assign done = (us_cnt == '0);
endmodule

// File: rtl/lpi_fsm.sv
module lpi_fsm
  import eee_lpi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_en,
  input  logic ctl_auto,
  input  logic ctl_link,
  input  logic rearm,
  input  logic link_stable,
  input  logic tx_idle,
  input  logic tx_pending,
  input  logic wake_done,
  output logic wake_load,
  output logic set_entered,
  output logic set_exited,
  output logic lpi_req,
  output logic tx_ready
);
  lpi_state_e state_q, state_d;
  logic any_en, may_enter, must_leave;

  assign any_en     = ctl_en | ctl_auto;
  assign may_enter  = link_stable && tx_idle && !tx_pending;
  assign must_leave = tx_pending || !any_en || !ctl_link;

  always_comb begin
    state_d     = state_q;
    wake_load   = 1'b0;
    set_entered = 1'b0;
    case (state_q)
      LPI_OFF:  if (any_en) state_d = LPI_ARM;
      LPI_ARM: begin
        if (!any_en) state_d = LPI_OFF;
        else if (may_enter) begin
          state_d     = LPI_ON;
          set_entered = 1'b1;
        end
      end
      LPI_ON: begin
        if (must_leave) begin
          state_d   = LPI_WAKE;
          wake_load = 1'b1;
        end
      end
      LPI_WAKE: if (wake_done) state_d = LPI_RUN;
      LPI_RUN: begin
        if (!any_en)               state_d = LPI_OFF;
        else if (ctl_auto || rearm) state_d = LPI_ARM;
      end
      default: state_d = LPI_OFF;
    endcase
  end

  assign set_exited = wake_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LPI_OFF;
    else        state_q <= state_d;
  end

  assign lpi_req  = (state_q == LPI_ON);
  assign tx_ready = !((state_q == LPI_ON) || (state_q == LPI_WAKE));
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int LS_W   = 10,
  parameter int TW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ms_tick,
  input  logic              us_tick,
  input  logic              tx_idle,
  input  logic              tx_pending,
  output logic              lpi_req,
  output logic              tx_ready,
  output logic              tx_clk_gate
);
  logic            rst_sync_n;
  logic            ctl_en, ctl_auto, ctl_link, ctl_gate, rearm;
  logic [LS_W-1:0] ls_time;
  logic [TW_W-1:0] tw_time;
  logic            sta_entered, sta_exited;
  logic            set_entered, set_exited;
  logic            link_stable, wake_load, wake_done;

  lpi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lpi_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LS_W(LS_W), .TW_W(TW_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .set_entered(set_entered), .set_exited(set_exited),
    .ctl_en(ctl_en), .ctl_auto(ctl_auto), .ctl_link(ctl_link), .ctl_gate(ctl_gate),
    .ls_time(ls_time), .tw_time(tw_time), .rearm(rearm),
    .sta_entered(sta_entered), .sta_exited(sta_exited)
  );

  lpi_link_timer #(.LS_W(LS_W)) u_link (
    .clk(clk), .rst_n(rst_sync_n), .link_ok(ctl_link), .ms_tick(ms_tick),
    .ls_time(ls_time), .link_stable(link_stable)
  );

  lpi_wake_timer #(.TW_W(TW_W)) u_wake (
    .clk(clk), .rst_n(rst_sync_n), .load(wake_load), .load_val(tw_time),
    .us_tick(us_tick), .done(wake_done)
  );

  lpi_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .ctl_en(ctl_en), .ctl_auto(ctl_auto), .ctl_link(ctl_link), .rearm(rearm),
    .link_stable(link_stable), .tx_idle(tx_idle), .tx_pending(tx_pending),
    .wake_done(wake_done), .wake_load(wake_load),
    .set_entered(set_entered), .set_exited(set_exited),
    .lpi_req(lpi_req), .tx_ready(tx_ready)
  );

  assign tx_clk_gate = lpi_req & ctl_gate;
endmodule

// File: rtl/lpi_ctrl_checker.sv
module lpi_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic lpi_req,
  input logic tx_ready,
  input logic clk_gate,
  input logic tx_idle,
  input logic tx_pending,
  input logic link_ok,
  input logic entered_flag
);
  p_gate_only_in_lpi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate |-> lpi_req);

  p_pending_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && tx_pending) |=> !lpi_req);

  p_link_drop_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && !link_ok) |=> !lpi_req);

  p_wake_blocks_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lpi_req) |-> !tx_ready);

  p_entry_needs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_req) |-> ($past(tx_idle) && !$past(tx_pending)));

  p_entry_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_req) |-> entered_flag);
endmodule

bind eee_lpi_ctrl lpi_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lpi_req(lpi_req), .tx_ready(tx_ready),
  .clk_gate(tx_clk_gate), .tx_idle(tx_idle), .tx_pending(tx_pending),
  .link_ok(ctl_link), .entered_flag(sta_entered)
);

// File: tb/sim_eee_lpi_ctrl.sv
`timescale 1ns/100ps
module sim_eee_lpi_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ms_tick = 1'b0, us_tick = 1'b0, tx_idle = 1'b1, tx_pending = 1'b0;
  logic        lpi_req, tx_ready, tx_clk_gate;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // behavioural reference state
  bit m_en, m_auto, m_link, m_gate, m_ent, m_ext;
  int m_ls, m_tw, m_ms, m_wake, m_mode; // mode: 0 off,1 armed,2 lpi,3 waking,4 running

  always #2.5 clk = ~clk;

  eee_lpi_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ms_tick(ms_tick), .us_tick(us_tick),
    .tx_idle(tx_idle), .tx_pending(tx_pending), .lpi_req(lpi_req),
    .tx_ready(tx_ready), .tx_clk_gate(tx_clk_gate)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    bit en, stable, rearm, rdclr, se, sx;
    int nmode;
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_auto = 0; m_link = 0; m_gate = 0; m_ent = 0; m_ext = 0;
      m_ls = 0; m_tw = 0; m_ms = 0; m_wake = 0; m_mode = 0;
    end else begin
      en     = m_en || m_auto;
      stable = m_link && (m_ms >= m_ls);
      rearm  = reg_wr && reg_addr == 2'd0 && reg_wdata[0];
      rdclr  = reg_rd && reg_addr == 2'd0;
      se = 0; sx = 0; nmode = m_mode;
      case (m_mode)
        0: if (en) nmode = 1;
        1: if (!en) nmode = 0;
           else if (stable && tx_idle && !tx_pending) begin nmode = 2; se = 1; end
        2: if (tx_pending || !en || !m_link) begin nmode = 3; sx = 1; m_wake = m_tw; end
        3: if (m_wake == 0) nmode = 4; else if (us_tick) m_wake--;
        4: if (!en) nmode = 0; else if (m_auto || rearm) nmode = 1;
        default: nmode = 0;
      endcase
      if (!m_link) m_ms = 0;
      else if (ms_tick && m_ms < m_ls) m_ms++;
      m_ent = se || (m_ent && !rdclr);
      m_ext = sx || (m_ext && !rdclr);
      if (reg_wr && reg_addr == 2'd0) begin
        m_en = reg_wdata[0]; m_auto = reg_wdata[1]; m_link = reg_wdata[2]; m_gate = reg_wdata[3];
      end
      if (reg_wr && reg_addr == 2'd1) begin
        m_ls = int'(reg_wdata[25:16]); m_tw = int'(reg_wdata[15:0]);
      end
      m_mode = nmode;
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      summary();
      $finish;
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 R5", "lpi_req vs model", {31'b0, lpi_req}, {31'b0, m_mode == 2});
      chk("R6", "tx_ready vs model", {31'b0, tx_ready}, {31'b0, !(m_mode == 2 || m_mode == 3)});
      chk("R8", "tx_clk_gate vs model", {31'b0, tx_clk_gate}, {31'b0, m_mode == 2 && m_gate});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1; reg_addr = a;
    #1;
    chk(req, "reg_rdata", reg_rdata, exp);
    step(1);
    reg_rd = 0;
  endtask

  task automatic tick_ms(input int n);
    for (int i = 0; i < n; i++) begin ms_tick = 1; step(1); ms_tick = 0; end
  endtask

  task automatic tick_us(input int n);
    for (int i = 0; i < n; i++) begin us_tick = 1; step(1); us_tick = 0; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(4);
    // R1 reset state
    chk("R1", "lpi_req", {31'b0, lpi_req}, 32'd0);
    chk("R1", "tx_ready", {31'b0, tx_ready}, 32'd1);
    chk("R1", "tx_clk_gate", {31'b0, tx_clk_gate}, 32'd0);
    rd_chk(2'd0, 32'h0, "R1");
    rd_chk(2'd1, 32'h0, "R1");
    // R2 register layout
    wr(2'd1, 32'hFC03_0005);
    rd_chk(2'd1, 32'h0003_0005, "R2");
    wr(2'd0, 32'hFFFF_F00D);
    rd_chk(2'd0, 32'h0000_000D, "R2");
    // R3 link-stable threshold of 3 ms ticks
    step(2);
    tick_ms(2);
    step(2);
    chk("R3", "no LPI before threshold", {31'b0, lpi_req}, 32'd0);
    tick_ms(1);
    step(1);
    chk("R3", "LPI after threshold", {31'b0, lpi_req}, 32'd1);
    chk("R8", "gate with enable", {31'b0, tx_clk_gate}, 32'd1);
    chk("R6", "tx blocked in LPI", {31'b0, tx_ready}, 32'd0);
    // R9 entry flag, cleared by read
    rd_chk(2'd0, 32'h0000_010D, "R9");
    rd_chk(2'd0, 32'h0000_000D, "R9");
    // R5 / R6 frame pending wakes, wake of 5 us ticks
    tx_pending = 1; step(1); tx_pending = 0;
    chk("R5", "drop on pending", {31'b0, lpi_req}, 32'd0);
    chk("R6", "tx blocked in wake", {31'b0, tx_ready}, 32'd0);
    rd_chk(2'd0, 32'h0000_020D, "R9");
    tick_us(4);
    chk("R6", "still waiting after 4 ticks", {31'b0, tx_ready}, 32'd0);
    tick_us(1);
    step(1);
    chk("R6", "released after wake", {31'b0, tx_ready}, 32'd1);
    // R7 manual mode stays running
    step(5);
    chk("R7", "no re-entry without rearm", {31'b0, lpi_req}, 32'd0);
    wr(2'd0, 32'h0000_000D);
    step(1);
    chk("R7", "rearm re-enters", {31'b0, lpi_req}, 32'd1);
    // R4 link-good dropped in LPI
    wr(2'd0, 32'h0000_0009);
    step(1);
    chk("R4", "exit on link down", {31'b0, lpi_req}, 32'd0);
    tick_ms(4);
    tick_us(5);
    step(2);
    wr(2'd0, 32'h0000_000D);
    tick_ms(2);
    step(1);
    chk("R4", "count restarted from zero", {31'b0, lpi_req}, 32'd0);
    tick_ms(1);
    step(1);
    chk("R4", "entry after fresh count", {31'b0, lpi_req}, 32'd1);
    // R10 busy transmitter blocks entry
    tx_pending = 1; step(1); tx_pending = 0; tx_idle = 0;
    tick_us(5);
    step(2);
    wr(2'd0, 32'h0000_000D);
    step(4);
    chk("R10", "busy blocks entry", {31'b0, lpi_req}, 32'd0);
    tx_pending = 1; tx_idle = 1; step(3);
    chk("R10", "pending blocks entry", {31'b0, lpi_req}, 32'd0);
    tx_pending = 0; step(1);
    chk("R10", "entry once idle", {31'b0, lpi_req}, 32'd1);
    // R5 clearing both enables leaves LPI
    wr(2'd0, 32'h0000_0004);
    step(1);
    chk("R5", "exit on disable", {31'b0, lpi_req}, 32'd0);
    tick_us(5);
    step(2);
    chk("R6", "ready after disable wake", {31'b0, tx_ready}, 32'd1);
    // R7 automatic re-entry, R8 gate disabled
    wr(2'd0, 32'h0000_0006);
    step(2);
    chk("R7", "auto entry", {31'b0, lpi_req}, 32'd1);
    chk("R8", "no gate when disabled", {31'b0, tx_clk_gate}, 32'd0);
    tx_pending = 1; step(1); tx_pending = 0;
    tick_us(5);
    step(3);
    chk("R7", "auto re-entry", {31'b0, lpi_req}, 32'd1);
    step(2);
    summary();
    $finish;
  end
endmodule